// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register file of a processor core in which the physical storage behind a register name depends on the current processor mode. Sixteen names (r0 to r15) are visible at any time. Two combinational read ports and one clocked write port take a 4-bit register name, and the current 5-bit mode input selects the bank. The program counter is r15 and lives in one shared location. Low registers r0 to r7 are also shared by every mode.

Each of the five exception modes has its own stack pointer (r13) and link register (r14). The fast-interrupt mode also has private copies of r8 to r14. A saved-status register exists for each exception mode. It has its own write strobe and read output, both addressed by the current mode. In user/system mode that status path falls through to the current status word, which is an input because it is held outside this block.

All ports are plain control and data pins. Reads are combinational. A write commits at the rising clock edge, so it is visible from the next cycle onwards.

Top module: `banked_regfile`

## Requirements
- R1: After the asynchronous active-low reset, every physical register and every saved-status register reads as zero.
- R2: Registers r0 to r7 are one set shared by every mode, so a write in any mode is read back in any other mode.
- R3: Register r15 is one location shared by every mode.
- R4: User mode (5'b10000) and system mode (5'b11111) address the same set r0 to r15. The non-fast exception modes also see that set's r8 to r12.
- R5: Supervisor (5'b10011), abort (5'b10111), undefined (5'b11011) and interrupt (5'b10010) modes each have a private r13 and r14. A write to one of these is not seen in any other mode.
- R6: Fast-interrupt mode (5'b10001) has private r8 to r14. These are separate from the user set and from every other bank.
- R7: Each exception mode has its own saved-status register. A write with sts_wr_en high is read back on sts_rd_data only while that same mode is selected.
- R8: In user or system mode, sts_rd_data equals cur_status_i, and a write with sts_wr_en high changes no saved-status register.
- R9: Any mode encoding not listed in R4 to R6 selects the user/system bank for both the registers and the status path.
- R10: When a read and a write address the same physical register in one cycle, the read returns the old value. The new value appears from the next cycle.
- R11: Both read ports are independent. When they carry the same name, they return the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current processor mode encoding |
| rd_a_idx | input | 4 | Read port A register name |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 4 | Read port B register name |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Write register name |
| wr_data | input | DW | Write data |
| cur_status_i | input | DW | Current status word, held outside the block |
| sts_wr_en | input | 1 | Saved-status write enable for the current mode |
| sts_wr_data | input | DW | Saved-status write data |
| sts_rd_data | output | DW | Saved status of the current mode, or cur_status_i in user/system mode |

## Verification
The bench targets aliasing between banks, for example writing r13 in one exception mode and reading it in every other mode. A design with an offset or slot error would return another mode's stack pointer, or clobber the user copy. Fast-interrupt r8 to r12 are tested against the user set, because a map that banks only r13/r14 would leak data there. User-mode status writes and unknown mode encodings are checked, since a wrong decode writes a real saved-status slot or falls into a private bank. Same-cycle read/write on one register is also checked, because a design that bypasses the write data would show the new value a cycle early.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
    BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5
  } bank_e;

  localparam int NAMES    = 16;
  localparam int N_EXC    = 5;
  localparam int FIQ_LO   = 8;
  localparam int FIQ_HI   = 14;
  localparam int SP_IDX   = 13;
  localparam int LR_IDX   = 14;
  localparam int FIQ_BASE = NAMES;
  localparam int FIQ_CNT  = FIQ_HI - FIQ_LO + 1;
  localparam int SP_BASE  = FIQ_BASE + FIQ_CNT;
  localparam int PHYS_N   = SP_BASE + 2 * (N_EXC - 1);

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;
endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import brf_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o
);
  always_comb begin
    unique case (mode_i)
      MD_FIQ:  bank_o = BK_FIQ;
      MD_IRQ:  bank_o = BK_IRQ;
      MD_SVC:  bank_o = BK_SVC;
      MD_ABT:  bank_o = BK_ABT;
      MD_UND:  bank_o = BK_UND;
      default: bank_o = BK_USR;
    endcase
  end
endmodule

// File: rtl/brf_phys_map.sv
module brf_phys_map
  import brf_pkg::*;
#(
  parameter int PAW = 5
) (
  input  bank_e          bank_i,
  input  logic [3:0]     idx_i,
  output logic [PAW-1:0] pidx_o
);
  int p;
  always_comb begin
    p = int'(idx_i);
    if (bank_i == BK_FIQ && p >= FIQ_LO && p <= FIQ_HI)
      p = FIQ_BASE + (p - FIQ_LO);
    else if (bank_i != BK_USR && bank_i != BK_FIQ && (p == SP_IDX || p == LR_IDX))
      p = SP_BASE + 2 * (int'(bank_i) - int'(BK_IRQ)) + (p - SP_IDX);
    pidx_o = PAW'(p);
  end
endmodule

// File: rtl/brf_storage.sv
module brf_storage #(
  parameter int DW    = 32,
  parameter int DEPTH = 31,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_a_o,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] rd_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mem_q[g] <= '0;
        else if (we_i && wa_i == AW'(g))     mem_q[g] <= wd_i;
      end
    end
  endgenerate

  assign rd_a_o = (int'(ra_i) < DEPTH) ? mem_q[ra_i] : '0;
  assign rd_b_o = (int'(rb_i) < DEPTH) ? mem_q[rb_i] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode_i,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] cur_status_i,
  input  logic          sts_wr_en,
  input  logic [DW-1:0] sts_wr_data,
  output logic [DW-1:0] sts_rd_data
);
  localparam int PAW = $clog2(PHYS_N);

  bank_e          bank;
  logic [PAW-1:0] pidx [3];
  logic [3:0]     name [3];

  assign name[0] = rd_a_idx;
  assign name[1] = rd_b_idx;
  assign name[2] = wr_idx;

  brf_mode_decode u_dec (.mode_i(mode_i), .bank_o(bank));

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_map
      brf_phys_map #(.PAW(PAW)) u_map (
        .bank_i(bank), .idx_i(name[g]), .pidx_o(pidx[g])
      );
    end
  endgenerate

  brf_storage #(.DW(DW), .DEPTH(PHYS_N), .AW(PAW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_en), .wa_i(pidx[2]), .wd_i(wr_data),
    .ra_i(pidx[0]), .rd_a_o(rd_a_data),
    .rb_i(pidx[1]), .rd_b_o(rd_b_data)
  );

  // Saved status: one slot per exception bank, slot = bank - 1.
  logic [DW-1:0] sts_q [N_EXC];
  logic [2:0]    slot;
  assign slot = 3'(int'(bank) - 1);

  generate
    for (g = 0; g < N_EXC; g++) begin : g_sts
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sts_q[g] <= '0;
        else if (sts_wr_en && bank != BK_USR && slot == 3'(g))
          sts_q[g] <= sts_wr_data;
      end
    end
  endgenerate

  assign sts_rd_data = (bank == BK_USR) ? cur_status_i : sts_q[slot];
endmodule

// File: rtl/brf_checker.sv
module brf_checker
  import brf_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    mode_i,
  input logic [3:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [3:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] cur_status_i,
  input logic [DW-1:0] sts_rd_data
);
  logic exc_mode;
  assign exc_mode = (mode_i == MD_FIQ) || (mode_i == MD_IRQ) || (mode_i == MD_SVC) ||
                    (mode_i == MD_ABT) || (mode_i == MD_UND);

  p_sts_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_mode |-> sts_rd_data == cur_status_i);

  p_ports_agree_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == rd_b_idx |-> rd_a_data == rd_b_data);

  p_low_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 4'd8 ##1 rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

  p_pc_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15 ##1 rd_b_idx == 4'd15)
      |-> rd_b_data == $past(wr_data));

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en ##1 (mode_i == $past(mode_i) && rd_a_idx == $past(wr_idx)))
      |-> rd_a_data == $past(wr_data));
endmodule

bind banked_regfile brf_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .cur_status_i(cur_status_i), .sts_rd_data(sts_rd_data)
);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    mode_i = 5'b10000;
  logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, sts_rd_data;
  logic          wr_en = 1'b0, sts_wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0, cur_status_i = '0, sts_wr_data = '0;

  int n_run = 0, n_fail = 0;

  always #5ns clk = ~clk;

  banked_regfile #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cur_status_i(cur_status_i), .sts_wr_en(sts_wr_en),
    .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data)
  );

  // Behavioural reference: one user set, one fast set, per-mode sp/lr, per-mode status.
  logic [DW-1:0] m_usr [16];
  logic [DW-1:0] m_fast [8:14];
  logic [DW-1:0] m_sp [6][2];
  logic [DW-1:0] m_sts [6];

  function automatic int which(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [DW-1:0] m_rd(input logic [3:0] r, input logic [4:0] m);
    int w = which(m);
    if (w == 1 && r >= 8 && r <= 14) return m_fast[r];
    if (w >= 2 && (r == 13 || r == 14)) return m_sp[w][r - 13];
    return m_usr[r];
  endfunction

  task automatic m_wr(input logic [3:0] r, input logic [4:0] m, input logic [DW-1:0] d);
    int w = which(m);
    if (w == 1 && r >= 8 && r <= 14) m_fast[r] = d;
    else if (w >= 2 && (r == 13 || r == 14)) m_sp[w][r - 13] = d;
    else m_usr[r] = d;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, compare combinational reads, commit at next rise.
  task automatic step(input string tag, input logic [4:0] m, input logic [3:0] ra,
                      input logic [3:0] rb, input logic we, input logic [3:0] wi,
                      input logic [DW-1:0] wd, input logic swe, input logic [DW-1:0] swd);
    logic [DW-1:0] cst = $urandom;
    mode_i = m; rd_a_idx = ra; rd_b_idx = rb; wr_en = we; wr_idx = wi; wr_data = wd;
    sts_wr_en = swe; sts_wr_data = swd; cur_status_i = cst;
    #1;
    chk({tag, " portA"}, rd_a_data, m_rd(ra, m));
    chk({tag, " portB"}, rd_b_data, m_rd(rb, m));
    chk({tag, " status"}, sts_rd_data, (which(m) == 0) ? cst : m_sts[which(m)]);
    @(posedge clk);
    if (we) m_wr(wi, m, wd);
    if (swe && which(m) != 0) m_sts[which(m)] = swd;
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [4:0] m, input logic [3:0] r);
    step(tag, m, r, r, 1'b0, 4'd0, '0, 1'b0, '0);
  endtask

  task automatic wr(input string tag, input logic [4:0] m, input logic [3:0] r,
                    input logic [DW-1:0] d);
    step(tag, m, r, 4'd0, 1'b1, r, d, 1'b0, '0);
  endtask

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

  initial begin
    #2_000_000ns;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] modes [8];
    modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, 5'b00000};
    for (int i = 0; i < 16; i++) m_usr[i] = '0;
    for (int i = 8; i <= 14; i++) m_fast[i] = '0;
    for (int i = 0; i < 6; i++) begin m_sp[i][0] = '0; m_sp[i][1] = '0; m_sts[i] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything zero after reset, every bank.
    for (int k = 0; k < 6; k++)
      for (int r = 0; r < 16; r++) rd("R1 reset", modes[k], 4'(r));

    // R2: low registers shared.
    wr("R2", SVC, 4'd3, 32'hA5A5_0003);
    rd("R2", FIQ, 4'd3); rd("R2", USR, 4'd3); rd("R2", IRQ, 4'd3);

    // R3: program counter shared.
    wr("R3", FIQ, 4'd15, 32'h0000_1F00);
    rd("R3", UND, 4'd15); rd("R3", USR, 4'd15);

    // R4: user/system one set; r8-r12 common to non-fast modes.
    wr("R4", SYS, 4'd13, 32'h5555_0013);
    rd("R4", USR, 4'd13);
    wr("R4", USR, 4'd10, 32'h0000_0A0A);
    rd("R4", SVC, 4'd10); rd("R4", ABT, 4'd10);

    // R5: private sp/lr per exception mode.
    wr("R5", IRQ, 4'd13, 32'h1111_0001);
    wr("R5", SVC, 4'd13, 32'h2222_0002);
    wr("R5", UND, 4'd14, 32'h3333_0003);
    rd("R5", IRQ, 4'd13); rd("R5", SVC, 4'd13); rd("R5", ABT, 4'd13);
    rd("R5", USR, 4'd13); rd("R5", UND, 4'd14); rd("R5", IRQ, 4'd14);

    // R6: fast mode private r8-r14.
    wr("R6", FIQ, 4'd8, 32'hF000_0008);
    wr("R6", FIQ, 4'd12, 32'hF000_000C);
    rd("R6", USR, 4'd8); rd("R6", FIQ, 4'd8); rd("R6", FIQ, 4'd12);
    rd("R6", SVC, 4'd12); rd("R6", FIQ, 4'd13);

    // R7: saved status per mode.
    step("R7", ABT, 4'd0, 4'd0, 1'b0, 4'd0, '0, 1'b1, 32'hABCD_0017);
    rd("R7", ABT, 4'd0); rd("R7", UND, 4'd0); rd("R7", FIQ, 4'd0);

    // R8: status write ignored in user/system, read passes through.
    step("R8", USR, 4'd0, 4'd0, 1'b0, 4'd0, '0, 1'b1, 32'hDEAD_0010);
    step("R8", SYS, 4'd0, 4'd0, 1'b0, 4'd0, '0, 1'b1, 32'hDEAD_001F);
    for (int k = 1; k < 6; k++) rd("R8", modes[k], 4'd0);
    rd("R8", USR, 4'd0);

    // R9: unknown encodings act as user.
    wr("R9", 5'b00000, 4'd14, 32'h9999_000E);
    rd("R9", USR, 4'd14);
    step("R9", 5'b10100, 4'd0, 4'd0, 1'b0, 4'd0, '0, 1'b1, 32'h0BAD_0BAD);
    for (int k = 1; k < 6; k++) rd("R9", modes[k], 4'd0);

    // R10: read during write returns old value, new value next cycle.
    step("R10", IRQ, 4'd13, 4'd13, 1'b1, 4'd13, 32'h0101_0101, 1'b0, '0);
    rd("R10", IRQ, 4'd13);
    step("R10", FIQ, 4'd9, 4'd1, 1'b1, 4'd9, 32'h0202_0202, 1'b0, '0);
    rd("R10", FIQ, 4'd9);

    // R11 plus R2-R6 under mixed traffic.
    for (int i = 0; i < 600; i++)
      step("R11 random", modes[$urandom_range(0, 7)], 4'($urandom), 4'($urandom),
           1'($urandom), 4'($urandom), $urandom, 1'($urandom), $urandom);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule